// File: doc/BRIEF.md
# Embedded Program/Erase Pulse-Limit Status Generator

This block sits inside a flash-style memory device. It runs one embedded program or erase at a time as a series of internal pulses, one per `pulse_tick`. A program whose new data only clears bits of the stored word finishes after a fixed number of pulses, and so does an erase. A program that would turn a stored 0 into a 1 cannot succeed, because only erase restores ones. The block marks that case as halted at once, but it keeps consuming pulses until the internal pulse-count limit is reached. It then raises the exceeded-limit status bit (`dq5_fail`) and holds it.

Only a reset command leaves the failed state. The block also tracks which read mode the device returns to afterwards. A program issued while an erase is suspended goes back to erase-suspend read. Every other operation goes back to normal array read. That applies both after a successful finish and after a failure cleared by reset.

Top module: `pe_limit_flag`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes idle: `busy`=0, `op_done`=0, `dq5_fail`=0, `halted`=0, and `rd_mode`=2'b00 (array read).
- R2: `op_start` while idle and not failed makes `busy`=1 and `rd_mode`=2'b10 (running) from the next cycle.
- R3: A program with `(old_data & new_data) == new_data` finishes on the PROG_PULSES-th counted tick. `op_done` is high for exactly one cycle, `busy` falls in that same cycle, and `dq5_fail` stays 0.
- R4: An erase (`op_is_erase`=1) finishes on the ERASE_PULSES-th counted tick, whatever the data inputs are.
- R5: A program in which any bit is 0 in `old_data` and 1 in `new_data` sets `halted`=1 from the cycle after start. It never raises `op_done`. It sets `dq5_fail`=1 and `rd_mode`=2'b11 on the PULSE_LIMIT-th counted tick.
- R6: Once `dq5_fail`=1, it stays 1 with `halted`=1 until a reset command arrives. `op_start` and `pulse_tick` have no effect while it is 1.
- R7: `reset_cmd` in the failed state clears `dq5_fail`, `halted` and `busy` on the next cycle. `rd_mode` then becomes 2'b01 if the failed program was started with `from_suspend`=1, and 2'b00 otherwise.
- R8: While an operation runs, `reset_cmd` and `op_start` are ignored. The pulse count continues and the outcome is unchanged.
- R9: After a successful program started with `from_suspend`=1, `rd_mode` is 2'b01. An erase ignores `from_suspend` and returns to 2'b00.
- R10: `pulse_tick` is only counted while running. Ticks while idle do not shorten the next operation, and gaps between ticks do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Start an embedded operation (one-cycle pulse) |
| op_is_erase | input | 1 | 1 = erase, 0 = program; sampled with `op_start` |
| from_suspend | input | 1 | Program issued while an erase is suspended; sampled with `op_start` |
| old_data | input | DATA_W | Word currently stored at the target; sampled with `op_start` |
| new_data | input | DATA_W | Word to be programmed; sampled with `op_start` |
| pulse_tick | input | 1 | One internal program/erase pulse |
| reset_cmd | input | 1 | Reset command from the command decoder |
| busy | output | 1 | Embedded operation in progress |
| op_done | output | 1 | One-cycle pulse on successful completion |
| dq5_fail | output | 1 | Exceeded-pulse-limit status bit |
| halted | output | 1 | Operation cannot succeed (running toward the limit, or failed) |
| rd_mode | output | 2 | 00 array read, 01 erase-suspend read, 10 running, 11 failed |

## Verification
The bench targets the 0-to-1 detection at the top and bottom bit positions. A design that tested the wrong direction (`old & ~new`) would finish a bad program after PROG_PULSES ticks, or fail a legal one. The bench counts ticks exactly, including idle ticks and gapped ticks. This exposes an off-by-one limit, which would raise `dq5_fail` one tick early or late, and a counter that keeps running while idle. It fires `reset_cmd` and `op_start` mid-run and in the failed state, where a design honouring them would abort or clear too early. It also checks the mode restored after reset and after completion, where a design that lost the suspend context would return to array read.

// File: rtl/pe_limit_pkg.sv
// Shared definitions for the program/erase pulse-limit block.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pe_limit_pkg;

    // Controller states: idle, running pulses, failed at limit.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FAIL = 2'd2
    } pe_state_t;

    // Encodings presented on rd_mode.
    localparam logic [1:0] MODE_ARRAY   = 2'b00;
    localparam logic [1:0] MODE_SUSPEND = 2'b01;
    localparam logic [1:0] MODE_RUNNING = 2'b10;
    localparam logic [1:0] MODE_FAILED  = 2'b11;

endpackage

// File: rtl/pe_bit_check.sv
// Detects a program request that would raise any stored 0 to a 1.
// Purely combinational. Assumes old/new words of equal width.
module pe_bit_check #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] new_word,
    output logic              raises_bit
);

    logic [DATA_W-1:0] per_bit;

    // One detector per bit: the new word wants a 1 where the old word holds a 0.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign per_bit[b] = new_word[b] & ~old_word[b];
    end

    // Any raising bit makes the request unprogrammable.
    assign raises_bit = |per_bit;

endmodule

// File: rtl/pe_pulse_ctr.sv
// Saturating pulse counter for the embedded operation.
// Assumes clr and inc are never meant together (clr wins).
module pe_pulse_ctr #(
    parameter int LIMIT = 16,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);

    // Count accepted pulses, hold at LIMIT, zero on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (clr)                   cnt <= '0;
        else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // R5: the count can never pass the pulse limit.
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);

    // R10: with no clear and no accepted pulse, the count holds.
    p_cnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt));

endmodule

// File: rtl/pe_limit_flag.sv
// Embedded program/erase sequencer with an exceeded-pulse-limit status bit.
// Counts pulse ticks while running. It finishes a legal program after
// PROG_PULSES ticks and an erase after ERASE_PULSES ticks. A program that
// raises a stored 0 runs to PULSE_LIMIT and then fails. Only reset_cmd
// leaves the failed state, and the restored read mode depends on the
// suspend context. Assumes PROG_PULSES and ERASE_PULSES are at least 1 and
// below PULSE_LIMIT, and that inputs are synchronous to clk.
module pe_limit_flag
    import pe_limit_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int PULSE_LIMIT  = 16,
    parameter int PROG_PULSES  = 4,
    parameter int ERASE_PULSES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_is_erase,
    input  logic              from_suspend,
    input  logic [DATA_W-1:0] old_data,
    input  logic [DATA_W-1:0] new_data,
    input  logic              pulse_tick,
    input  logic              reset_cmd,
    output logic              busy,
    output logic              op_done,
    output logic              dq5_fail,
    output logic              halted,
    output logic [1:0]        rd_mode
);

    localparam int CW = $clog2(PULSE_LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_LAST = CW'(PULSE_LIMIT - 1);
    localparam logic [CW-1:0] PROG_LAST  = CW'(PROG_PULSES - 1);
    localparam logic [CW-1:0] ERASE_LAST = CW'(ERASE_PULSES - 1);

    pe_state_t         state_q, state_d;
    logic [CW-1:0]     cnt;
    logic              bad_req, bad_q, erase_q, susp_q, home_susp_q;
    logic              tick_run, reach_need, reach_lim, done_q;

    pe_bit_check #(.DATA_W(DATA_W)) u_check (
        .old_word   (old_data),
        .new_word   (new_data),
        .raises_bit (bad_req)
    );

    pe_pulse_ctr #(.LIMIT(PULSE_LIMIT), .CW(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_RUN),
        .inc   (tick_run),
        .cnt   (cnt)
    );

    // Pulse accepted this cycle and the two terminal conditions it may hit.
    always_comb begin
        tick_run   = (state_q == ST_RUN) && pulse_tick;
        reach_need = tick_run && !bad_q && (cnt == (erase_q ? ERASE_LAST : PROG_LAST));
        reach_lim  = tick_run && (cnt == LIMIT_LAST);
    end

    // Next-state selection; completion takes priority over the limit.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (op_start)       state_d = ST_RUN;
            ST_RUN:  if (reach_need)     state_d = ST_IDLE;
                     else if (reach_lim) state_d = ST_FAIL;
            ST_FAIL: if (reset_cmd)      state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // State register and the one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_RUN) && reach_need;
        end
    end

    // Capture the operation context when a new operation is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_q   <= 1'b0;
            erase_q <= 1'b0;
            susp_q  <= 1'b0;
        end else if (state_q == ST_IDLE && op_start) begin
            bad_q   <= !op_is_erase && bad_req;
            erase_q <= op_is_erase;
            susp_q  <= !op_is_erase && from_suspend;
        end
    end

    // Read mode to return to once idle: updated on completion or reset command.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    home_susp_q <= 1'b0;
        else if (state_q == ST_RUN && reach_need)      home_susp_q <= susp_q;
        else if (state_q == ST_FAIL && reset_cmd)      home_susp_q <= susp_q;
    end

    // Status outputs decoded from state.
    always_comb begin
        busy     = (state_q == ST_RUN);
        dq5_fail = (state_q == ST_FAIL);
        halted   = bad_q && (state_q != ST_IDLE);
        op_done  = done_q;
        unique case (state_q)
            ST_RUN:  rd_mode = MODE_RUNNING;
            ST_FAIL: rd_mode = MODE_FAILED;
            default: rd_mode = home_susp_q ? MODE_SUSPEND : MODE_ARRAY;
        endcase
    end

    // R2: an accepted start makes the block busy next cycle.
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !dq5_fail && op_start) |=> busy);

    // R3: completion lasts one cycle and is never seen while busy.
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> (!busy && !dq5_fail) ##1 !op_done);

    // R5: a halted operation never reports success.
    p_halt_no_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !op_done);

    // R6: the failure flag persists until a reset command.
    p_dq5_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dq5_fail && !reset_cmd) |=> (dq5_fail && halted));

    // R7: a reset command in the failed state clears it.
    p_dq5_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dq5_fail && reset_cmd) |=> (!dq5_fail && !busy && !halted));

    // R8: a running operation cannot be aborted by reset_cmd.
    p_run_no_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pulse_tick) |=> busy);

endmodule

// File: tb/tb_pe_limit_flag.sv
`timescale 1ns/1ps
module tb_pe_limit_flag;

    localparam int DW    = 16;
    localparam int LIM   = 16;
    localparam int PROGN = 4;
    localparam int ERAN  = 10;

    typedef struct packed {
        logic          erase;
        logic          susp;
        logic [DW-1:0] old_w;
        logic [DW-1:0] new_w;
        logic          fails;
        logic [7:0]    ticks;
        logic [1:0]    mode;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 16'hFFFF, 16'h1234, 1'b0, 8'(PROGN), 2'b00},  // R3
        '{1'b0, 1'b1, 16'h00F0, 16'h0030, 1'b0, 8'(PROGN), 2'b01},  // R9
        '{1'b0, 1'b0, 16'h0000, 16'h0001, 1'b1, 8'(LIM),   2'b00},  // R5 LSB
        '{1'b0, 1'b1, 16'h7FFF, 16'hFFFF, 1'b1, 8'(LIM),   2'b01},  // R5/R7 MSB
        '{1'b1, 1'b1, 16'h0000, 16'hFFFF, 1'b0, 8'(ERAN),  2'b00},  // R4/R9
        '{1'b0, 1'b0, 16'hA5A5, 16'hA5A5, 1'b0, 8'(PROGN), 2'b00},  // R3
        '{1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 8'(PROGN), 2'b00}   // R3
    };

    logic          clk = 1'b0;
    logic          rst_n, op_start, op_is_erase, from_suspend, pulse_tick, reset_cmd;
    logic [DW-1:0] old_data, new_data;
    logic          busy, op_done, dq5_fail, halted;
    logic [1:0]    rd_mode;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pe_limit_flag #(.DATA_W(DW), .PULSE_LIMIT(LIM), .PROG_PULSES(PROGN),
                    .ERASE_PULSES(ERAN)) dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
        .from_suspend(from_suspend), .old_data(old_data), .new_data(new_data),
        .pulse_tick(pulse_tick), .reset_cmd(reset_cmd), .busy(busy),
        .op_done(op_done), .dq5_fail(dq5_fail), .halted(halted), .rd_mode(rd_mode)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // Start an operation; the sampled values are held for one edge.
    task automatic start_op(input logic er, input logic su, input logic [DW-1:0] o,
                            input logic [DW-1:0] n);
        op_start = 1'b1; op_is_erase = er; from_suspend = su;
        old_data = o; new_data = n;
        cyc();
        op_start = 1'b0; old_data = ~o; new_data = ~n;
    endtask

    // Tick every cycle until done or fail; returns ticks used.
    task automatic run_ticks(output int used);
        used = 0;
        for (int k = 1; k <= 40; k++) begin
            pulse_tick = 1'b1;
            cyc();
            used = k;
            if (op_done || dq5_fail) break;
        end
        pulse_tick = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int used;
        rst_n = 1'b0; op_start = 1'b0; op_is_erase = 1'b0; from_suspend = 1'b0;
        pulse_tick = 1'b0; reset_cmd = 1'b0; old_data = '0; new_data = '0;
        cyc(); cyc();
        // R1: reset state
        check(!busy && !op_done && !dq5_fail && !halted, "R1 flags", {busy, op_done, dq5_fail, halted}, 0);
        check(rd_mode == 2'b00, "R1 mode", rd_mode, 0);
        rst_n = 1'b1;
        cyc();

        for (int v = 0; v < NV; v++) begin
            start_op(VECS[v].erase, VECS[v].susp, VECS[v].old_w, VECS[v].new_w);
            check(busy && rd_mode == 2'b10, "R2 busy", rd_mode, 2);
            check(halted == VECS[v].fails, "R5 halted", halted, VECS[v].fails);
            run_ticks(used);
            check(used == VECS[v].ticks, "R3/R4/R5 tick count", used, VECS[v].ticks);
            if (VECS[v].fails) begin
                check(dq5_fail && !op_done && rd_mode == 2'b11, "R5 fail", rd_mode, 3);
                reset_cmd = 1'b1; cyc(); reset_cmd = 1'b0;
                check(!dq5_fail && !halted && !busy, "R7 clear", dq5_fail, 0);
                check(rd_mode == VECS[v].mode, "R7 mode", rd_mode, VECS[v].mode);
            end else begin
                check(op_done && !busy && !dq5_fail, "R3 done", op_done, 1);
                cyc();
                check(!op_done, "R3 one-cycle done", op_done, 0);
                check(rd_mode == VECS[v].mode, "R9 mode", rd_mode, VECS[v].mode);
            end
        end

        // R10: idle ticks then gapped ticks; program still needs PROGN ticks
        pulse_tick = 1'b1; cyc(); cyc(); cyc(); pulse_tick = 1'b0;
        check(!busy && !op_done, "R10 idle ticks", busy, 0);
        start_op(1'b0, 1'b0, 16'hFFFF, 16'h00FF);
        used = 0;
        for (int k = 0; k < 12 && !op_done; k++) begin
            pulse_tick = k[0];
            cyc();
            if (pulse_tick) used++;
        end
        pulse_tick = 1'b0;
        check(op_done && used == PROGN, "R10 gapped count", used, PROGN);
        cyc();

        // R8: reset_cmd and op_start mid-run are ignored
        start_op(1'b0, 1'b0, 16'h0000, 16'h8000);
        for (int k = 0; k < 5; k++) begin pulse_tick = 1'b1; cyc(); end
        pulse_tick = 1'b0; reset_cmd = 1'b1; op_start = 1'b1;
        old_data = 16'hFFFF; new_data = 16'h0000; op_is_erase = 1'b0;
        cyc();
        reset_cmd = 1'b0; op_start = 1'b0;
        check(busy && halted, "R8 still running", busy, 1);
        run_ticks(used);
        check(dq5_fail && used == LIM - 5, "R8 count kept", used, LIM - 5);

        // R6: ticks and start ignored while failed
        op_start = 1'b1; pulse_tick = 1'b1; cyc(); cyc();
        op_start = 1'b0; pulse_tick = 1'b0; cyc();
        check(dq5_fail && halted && rd_mode == 2'b11, "R6 hold", rd_mode, 3);
        reset_cmd = 1'b1; cyc(); reset_cmd = 1'b0;
        check(!dq5_fail && rd_mode == 2'b00, "R7 array", rd_mode, 0);

        // R1: reset in mid-run
        start_op(1'b1, 1'b0, 16'h0, 16'h0);
        pulse_tick = 1'b1; cyc(); pulse_tick = 1'b0;
        rst_n = 1'b0; cyc(); rst_n = 1'b1;
        check(!busy && !dq5_fail && !halted && rd_mode == 2'b00, "R1 mid-run reset", busy, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule